// File: doc/BRIEF.md
# Overlapped-Arbitration Bus Node

This block is the arbitration logic for one node on a serial bus built from point-to-point, dual-simplex links. Arbitration runs while data is still moving. Every port delivers one decoded token per clock. The node remembers the latest request that each port and the local link have made. Every request carries a class: current fairness interval or next interval. It also carries a priority. The node sends the strongest of these requests back along the port that faces the current transmitter, which is the boss. Requests therefore travel against the data stream and reach the boss before its packet ends.

Grant and arbitration-reset symbols always come in pairs. The node acts only on the second copy of a pair. A confirmed grant goes either to the local link or, as a fresh pair, out of the one port that holds the winning request. A confirmed arbitration reset goes out of every other port and raises every waiting next-interval request to the current interval. When the local link finishes its own packet, the node becomes boss. It then grants the best current-interval request. If only next-interval requests are waiting, it first starts a new fairness interval with an arbitration reset.

Top module: `arb_node`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every port transmits nothing (tx_valid low), and lgrant, lreset and boss are low.
- R2: Token kind codes are 0 idle, 1 request, 2 data, 3 end of packet, 4 end of packet with grant, 5 arbitration reset. A data or end-of-packet token received on a port is repeated on every other port in the next cycle. The most recent port to deliver data becomes the upstream port.
- R3: In the cycle after a request is captured, the upstream port carries a request token with the class and priority of the best stored request. No request is sent while the node is boss, while it is transmitting, or before any data has arrived since reset or since it last became boss.
- R4: Selection order for the best request: a current-interval request (class bit 0) beats a next-interval request (class bit 1). Within a class the higher priority value wins, then the lower source index. The local link is source 0 and port p is source p+1.
- R5: A grant or arbitration-reset token is acted on only when it arrives on a port in two consecutive cycles. A single copy has no effect.
- R6: A confirmed grant goes to the best request. If the local link wins, lgrant pulses for one cycle and the node becomes transmitter. If a port wins, a grant pair leaves that port only. Either way the winner's request is cleared, and with no stored request the grant is dropped.
- R7: A confirmed arbitration reset is repeated as a pair on every port except the one it arrived on. lreset pulses, and every stored next-interval request becomes current-interval.
- R8: A pulse on lsend_done makes the node boss. Once the boss holds a current-interval request, it grants it in the following cycle, in the same way as R6, and then gives up the boss role.
- R9: A boss that holds only next-interval requests sends an arbitration-reset pair on all ports, pulses lreset and promotes those requests. The grant follows right after the pair.
- R10: Every grant or arbitration-reset symbol the node sends appears on its port in exactly two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | NPORTS | Token present on each port's receive side |
| rx_kind | input | 3*NPORTS | Token kind per port, port p in bits [3p+2:3p] |
| rx_nxt | input | NPORTS | Request class per port, 1 = next interval |
| rx_pri | input | PRI_W*NPORTS | Request priority per port, port p in bits [PRI_W*p +: PRI_W] |
| tx_valid | output | NPORTS | Token present on each port's transmit side |
| tx_kind | output | 3*NPORTS | Transmitted token kind per port |
| tx_nxt | output | NPORTS | Transmitted request class per port |
| tx_pri | output | PRI_W*NPORTS | Transmitted request priority per port |
| lreq_valid | input | 1 | Local link places or replaces its request |
| lreq_nxt | input | 1 | Local request class, 1 = next interval |
| lreq_pri | input | PRI_W | Local request priority |
| lsend_done | input | 1 | Local link has sent its end of packet |
| lgrant | output | 1 | One-cycle pulse: local link may transmit |
| lreset | output | 1 | One-cycle pulse: new fairness interval started |
| boss | output | 1 | Node currently decides the next transmitter |

## Verification
A wrong stored request shows up in the cycle after capture as a wrong class or priority in the request token on the upstream port. A wrong request state therefore never stays hidden for long. A fault in the pair logic, in the routing or in promotion is seen at the second copy of the incoming pair, when a grant pair appears on a wrong port, or an lgrant or lreset pulse appears where none is due or is missing. Every control symbol and local pulse is matched, in order and cycle by cycle, against a queue of expected events. A stray, extra or missing symbol is reported at the first cycle where the two sequences differ.

// File: rtl/arb_node_pkg.sv
`timescale 1ns/1ps
package arb_node_pkg;
   localparam int KIND_W = 3;

   typedef enum logic [KIND_W-1:0] {
      TK_IDLE      = 3'd0,
      TK_REQ       = 3'd1,
      TK_DATA      = 3'd2,
      TK_EOP       = 3'd3,
      TK_EOP_GRANT = 3'd4,
      TK_ARB_RESET = 3'd5
   } tok_kind_e;

   function automatic logic is_ctl(logic [KIND_W-1:0] k);
      return (k == TK_EOP_GRANT) || (k == TK_ARB_RESET);
   endfunction
endpackage

// File: rtl/arb_req_store.sv
`timescale 1ns/1ps
// Per-source request registers: one slot for the local link and one per port.
module arb_req_store #(
   parameter int NSRC  = 4,
   parameter int PRI_W = 2
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [NSRC-1:0]       set_vld,
   input  logic [NSRC-1:0]       set_nxt,
   input  logic [NSRC*PRI_W-1:0] set_pri,
   input  logic [NSRC-1:0]       clr,
   input  logic                  promote,
   output logic [NSRC-1:0]       req_vld,
   output logic [NSRC-1:0]       req_nxt,
   output logic [NSRC*PRI_W-1:0] req_pri
);
   for (genvar s = 0; s < NSRC; s++) begin : g_slot
      always_ff @(posedge clk) begin
         if (rst) begin
            req_vld[s]                  <= 1'b0;
            req_nxt[s]                  <= 1'b0;
            req_pri[s*PRI_W +: PRI_W]   <= '0;
         end else if (set_vld[s]) begin
            // a fresh request wins over a clear in the same cycle
            req_vld[s]                  <= 1'b1;
            req_nxt[s]                  <= set_nxt[s];
            req_pri[s*PRI_W +: PRI_W]   <= set_pri[s*PRI_W +: PRI_W];
         end else begin
            if (clr[s])  req_vld[s] <= 1'b0;
            if (promote) req_nxt[s] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/arb_pick.sv
`timescale 1ns/1ps
// Picks the strongest stored request: class, then priority, then lowest index.
module arb_pick #(
   parameter int NSRC  = 4,
   parameter int PRI_W = 2,
   localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic [NSRC-1:0]       req_vld,
   input  logic [NSRC-1:0]       req_nxt,
   input  logic [NSRC*PRI_W-1:0] req_pri,
   output logic                  best_vld,
   output logic [IDX_W-1:0]      best_idx,
   output logic                  best_nxt,
   output logic [PRI_W-1:0]      best_pri
);
   logic [PRI_W:0] key, best_key;

   always_comb begin
      best_vld = 1'b0;
      best_idx = '0;
      best_nxt = 1'b0;
      best_pri = '0;
      best_key = '0;
      key      = '0;
      for (int s = 0; s < NSRC; s++) begin
         key = {~req_nxt[s], req_pri[s*PRI_W +: PRI_W]};
         // strict compare keeps the lowest index on a tie
         if (req_vld[s] && (!best_vld || key > best_key)) begin
            best_vld = 1'b1;
            best_idx = IDX_W'(s);
            best_nxt = req_nxt[s];
            best_pri = req_pri[s*PRI_W +: PRI_W];
            best_key = key;
         end
      end
   end
endmodule

// File: rtl/arb_pair_det.sv
`timescale 1ns/1ps
// Confirms a control symbol once the same one arrives twice in a row on a port.
module arb_pair_det
   import arb_node_pkg::*;
#(
   parameter int NPORTS = 3
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [NPORTS-1:0]        rx_valid,
   input  logic [KIND_W*NPORTS-1:0] rx_kind,
   output logic [NPORTS-1:0]        hit
);
   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      logic [KIND_W-1:0] last_q;
      logic [KIND_W-1:0] kin;

      assign kin    = rx_kind[p*KIND_W +: KIND_W];
      assign hit[p] = rx_valid[p] && is_ctl(kin) && (last_q == kin);

      always_ff @(posedge clk) begin
         if (rst)                     last_q <= TK_IDLE;
         else if (!rx_valid[p])       last_q <= TK_IDLE;
         else if (hit[p])             last_q <= TK_IDLE; // a third copy starts a new pair
         else                         last_q <= kin;
      end
   end
endmodule

// File: rtl/arb_node.sv
`timescale 1ns/1ps
module arb_node
   import arb_node_pkg::*;
#(
   parameter int NPORTS = 3,
   parameter int PRI_W  = 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [NPORTS-1:0]        rx_valid,
   input  logic [3*NPORTS-1:0]      rx_kind,
   input  logic [NPORTS-1:0]        rx_nxt,
   input  logic [PRI_W*NPORTS-1:0]  rx_pri,
   output logic [NPORTS-1:0]        tx_valid,
   output logic [3*NPORTS-1:0]      tx_kind,
   output logic [NPORTS-1:0]        tx_nxt,
   output logic [PRI_W*NPORTS-1:0]  tx_pri,
   input  logic                     lreq_valid,
   input  logic                     lreq_nxt,
   input  logic [PRI_W-1:0]         lreq_pri,
   input  logic                     lsend_done,
   output logic                     lgrant,
   output logic                     lreset,
   output logic                     boss
);
   localparam int NSRC   = NPORTS + 1;
   localparam int IDX_W  = $clog2(NSRC);
   localparam int PIDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;
   localparam logic [NPORTS-1:0] ALL_PORTS = {NPORTS{1'b1}};

   if (NPORTS < 2) begin : g_bad_ports
      $error("arb_node: NPORTS must be at least 2");
   end
   if (PRI_W < 1) begin : g_bad_pri
      $error("arb_node: PRI_W must be at least 1");
   end

   // ---------------- request capture ----------------
   logic [NSRC-1:0]       set_vld, set_nxt, clr;
   logic [NSRC*PRI_W-1:0] set_pri;
   logic [NSRC-1:0]       req_vld, req_nxt;
   logic [NSRC*PRI_W-1:0] req_pri;
   logic                  promote;

   assign set_vld[0]         = lreq_valid;
   assign set_nxt[0]         = lreq_nxt;
   assign set_pri[0 +: PRI_W] = lreq_pri;
   for (genvar p = 0; p < NPORTS; p++) begin : g_cap
      assign set_vld[p+1] = rx_valid[p] && (rx_kind[3*p +: 3] == TK_REQ);
      assign set_nxt[p+1] = rx_nxt[p];
      assign set_pri[(p+1)*PRI_W +: PRI_W] = rx_pri[p*PRI_W +: PRI_W];
   end

   arb_req_store #(.NSRC(NSRC), .PRI_W(PRI_W)) u_store (
      .clk(clk), .rst(rst), .set_vld(set_vld), .set_nxt(set_nxt),
      .set_pri(set_pri), .clr(clr), .promote(promote),
      .req_vld(req_vld), .req_nxt(req_nxt), .req_pri(req_pri)
   );

   logic             best_vld, best_nxt;
   logic [IDX_W-1:0] best_idx;
   logic [PRI_W-1:0] best_pri;

   arb_pick #(.NSRC(NSRC), .PRI_W(PRI_W)) u_pick (
      .req_vld(req_vld), .req_nxt(req_nxt), .req_pri(req_pri),
      .best_vld(best_vld), .best_idx(best_idx),
      .best_nxt(best_nxt), .best_pri(best_pri)
   );

   // ---------------- control pair detection ----------------
   logic [NPORTS-1:0] hit;

   arb_pair_det #(.NPORTS(NPORTS)) u_pair (
      .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_kind(rx_kind), .hit(hit)
   );

   logic              hit_any;
   logic [PIDX_W-1:0] hit_port;
   logic [2:0]        hit_kind;
   logic              dat_any, dat_is_data;
   logic [PIDX_W-1:0] dat_port;
   logic [2:0]        dat_kind;

   always_comb begin
      hit_any = 1'b0; hit_port = '0; hit_kind = TK_IDLE;
      dat_any = 1'b0; dat_port = '0; dat_kind = TK_IDLE; dat_is_data = 1'b0;
      for (int p = NPORTS-1; p >= 0; p--) begin
         if (hit[p]) begin
            hit_any  = 1'b1;
            hit_port = PIDX_W'(p);
            hit_kind = rx_kind[3*p +: 3];
         end
         if (rx_valid[p] && (rx_kind[3*p +: 3] == TK_DATA ||
                             rx_kind[3*p +: 3] == TK_EOP)) begin
            dat_any     = 1'b1;
            dat_port    = PIDX_W'(p);
            dat_kind    = rx_kind[3*p +: 3];
            dat_is_data = (rx_kind[3*p +: 3] == TK_DATA);
         end
      end
   end

   // ---------------- state ----------------
   logic              up_vld_q;
   logic [PIDX_W-1:0] up_port_q;
   logic              rep_vld_q;
   logic [2:0]        rep_kind_q;
   logic [PIDX_W-1:0] rep_src_q;
   logic [1:0]        emit_cnt_q;
   logic [2:0]        emit_kind_q;
   logic [NPORTS-1:0] emit_mask_q;
   logic              boss_q, xmit_q, lgrant_q, lreset_q;

   logic              emit_free;
   assign emit_free = (emit_cnt_q <= 2'd1);

   // ---------------- decisions ----------------
   logic              ld_emit;
   logic [2:0]        ld_kind;
   logic [NPORTS-1:0] ld_mask;
   logic              give_local, boss_clr;
   logic [NPORTS-1:0] win_mask;
   logic [NSRC-1:0]   win_src;

   always_comb begin
      win_mask = '0;
      win_src  = '0;
      for (int s = 0; s < NSRC; s++) begin
         if (best_idx == IDX_W'(s)) win_src[s] = 1'b1;
      end
      for (int p = 0; p < NPORTS; p++) begin
         if (best_idx == IDX_W'(p+1)) win_mask[p] = 1'b1;
      end
   end

   always_comb begin
      ld_emit    = 1'b0;
      ld_kind    = TK_IDLE;
      ld_mask    = '0;
      promote    = 1'b0;
      give_local = 1'b0;
      boss_clr   = 1'b0;
      clr        = '0;
      if (emit_free && hit_any) begin
         if (hit_kind == TK_EOP_GRANT) begin
            if (best_vld) begin
               clr = win_src;
               if (best_idx == '0) begin
                  give_local = 1'b1;
               end else begin
                  ld_emit = 1'b1;
                  ld_kind = TK_EOP_GRANT;
                  ld_mask = win_mask;
               end
            end
         end else begin
            ld_emit = 1'b1;
            ld_kind = TK_ARB_RESET;
            ld_mask = ALL_PORTS & ~(NPORTS'(1) << hit_port);
            promote = 1'b1;
         end
      end else if (emit_free && boss_q && best_vld) begin
         if (!best_nxt) begin
            clr      = win_src;
            boss_clr = 1'b1;
            if (best_idx == '0) begin
               give_local = 1'b1;
            end else begin
               ld_emit = 1'b1;
               ld_kind = TK_EOP_GRANT;
               ld_mask = win_mask;
            end
         end else begin
            ld_emit = 1'b1;
            ld_kind = TK_ARB_RESET;
            ld_mask = ALL_PORTS;
            promote = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         up_vld_q    <= 1'b0;
         up_port_q   <= '0;
         rep_vld_q   <= 1'b0;
         rep_kind_q  <= TK_IDLE;
         rep_src_q   <= '0;
         emit_cnt_q  <= '0;
         emit_kind_q <= TK_IDLE;
         emit_mask_q <= '0;
         boss_q      <= 1'b0;
         xmit_q      <= 1'b0;
         lgrant_q    <= 1'b0;
         lreset_q    <= 1'b0;
      end else begin
         rep_vld_q  <= dat_any;
         rep_kind_q <= dat_kind;
         rep_src_q  <= dat_port;

         if (ld_emit) begin
            emit_cnt_q  <= 2'd2;
            emit_kind_q <= ld_kind;
            emit_mask_q <= ld_mask;
         end else if (emit_cnt_q != 2'd0) begin
            emit_cnt_q  <= emit_cnt_q - 2'd1;
         end

         lgrant_q <= give_local;
         lreset_q <= promote;

         if (lsend_done) begin
            boss_q   <= 1'b1;
            xmit_q   <= 1'b0;
            up_vld_q <= 1'b0;
         end else begin
            if (boss_clr)   boss_q <= 1'b0;
            if (give_local) xmit_q <= 1'b1;
            if (dat_any && dat_is_data) begin
               up_vld_q  <= 1'b1;
               up_port_q <= dat_port;
            end
         end
      end
   end

   // ---------------- transmit side ----------------
   logic fwd_en;
   assign fwd_en = up_vld_q && !boss_q && !xmit_q;

   for (genvar p = 0; p < NPORTS; p++) begin : g_tx
      always_comb begin
         tx_valid[p]               = 1'b0;
         tx_kind[3*p +: 3]         = TK_IDLE;
         tx_nxt[p]                 = 1'b0;
         tx_pri[p*PRI_W +: PRI_W]  = '0;
         if (emit_cnt_q != 2'd0 && emit_mask_q[p]) begin
            tx_valid[p]       = 1'b1;
            tx_kind[3*p +: 3] = emit_kind_q;
         end else if (fwd_en && best_vld && up_port_q == PIDX_W'(p)) begin
            tx_valid[p]              = 1'b1;
            tx_kind[3*p +: 3]        = TK_REQ;
            tx_nxt[p]                = best_nxt;
            tx_pri[p*PRI_W +: PRI_W] = best_pri;
         end else if (rep_vld_q && rep_src_q != PIDX_W'(p)) begin
            tx_valid[p]       = 1'b1;
            tx_kind[3*p +: 3] = rep_kind_q;
         end
      end
   end

   assign lgrant = lgrant_q;
   assign lreset = lreset_q;
   assign boss   = boss_q;
endmodule

// File: rtl/arb_node_chk.sv
`timescale 1ns/1ps
module arb_node_chk
   import arb_node_pkg::*;
#(
   parameter int NPORTS = 3,
   parameter int PRI_W  = 2
) (
   input logic                    clk,
   input logic                    rst,
   input logic [NPORTS-1:0]       tx_valid,
   input logic [3*NPORTS-1:0]     tx_kind,
   input logic                    lgrant,
   input logic                    lreset,
   input logic                    boss
);
   logic [NPORTS-1:0] g_vec, a_vec, r_vec;

   for (genvar p = 0; p < NPORTS; p++) begin : g_p
      logic ctl;
      assign g_vec[p] = tx_valid[p] && tx_kind[3*p +: 3] == TK_EOP_GRANT;
      assign a_vec[p] = tx_valid[p] && tx_kind[3*p +: 3] == TK_ARB_RESET;
      assign r_vec[p] = tx_valid[p] && tx_kind[3*p +: 3] == TK_REQ;
      assign ctl      = g_vec[p] || a_vec[p];

      // R10
      pair_rep_chk: assert property (@(posedge clk) disable iff (rst)
         $rose(ctl) |=> (ctl && $stable(tx_kind[3*p +: 3])));
   end

   // R6
   grant_single_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(g_vec) <= 1);

   // R6
   lgrant_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      lgrant |=> !lgrant);

   // R3
   boss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      boss |-> (r_vec == '0));

   // R7
   lreset_out_chk: assert property (@(posedge clk) disable iff (rst)
      lreset |-> (a_vec != '0));

   // R8
   lgrant_noboss_chk: assert property (@(posedge clk) disable iff (rst)
      lgrant |-> !boss);
endmodule

bind arb_node arb_node_chk #(.NPORTS(NPORTS), .PRI_W(PRI_W)) u_chk (
   .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_kind(tx_kind),
   .lgrant(lgrant), .lreset(lreset), .boss(boss)
);

// File: tb/arb_node_test.sv
`timescale 1ns/1ps
module arb_node_test;
   import arb_node_pkg::*;
   localparam int NP = 3;
   localparam int PW = 2;
   localparam int EV_LG = 100;
   localparam int EV_LR = 101;

   logic clk = 1'b0, rst = 1'b1;
   logic [NP-1:0]    rx_valid = '0, rx_nxt = '0;
   logic [3*NP-1:0]  rx_kind  = '0;
   logic [PW*NP-1:0] rx_pri   = '0;
   logic [NP-1:0]    tx_valid, tx_nxt;
   logic [3*NP-1:0]  tx_kind;
   logic [PW*NP-1:0] tx_pri;
   logic lreq_valid = 1'b0, lreq_nxt = 1'b0, lsend_done = 1'b0;
   logic [PW-1:0] lreq_pri = '0;
   logic lgrant, lreset, boss;

   int n_chk = 0, n_fail = 0;
   int    exp_q[$];
   string tag_q[$];

   always #2.5 clk = ~clk;

   arb_node #(.NPORTS(NP), .PRI_W(PW)) uut (
      .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_kind(rx_kind),
      .rx_nxt(rx_nxt), .rx_pri(rx_pri), .tx_valid(tx_valid),
      .tx_kind(tx_kind), .tx_nxt(tx_nxt), .tx_pri(tx_pri),
      .lreq_valid(lreq_valid), .lreq_nxt(lreq_nxt), .lreq_pri(lreq_pri),
      .lsend_done(lsend_done), .lgrant(lgrant), .lreset(lreset), .boss(boss)
   );

   task automatic chk(bit ok, string tag, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic push(int ev, string tag);
      exp_q.push_back(ev);
      tag_q.push_back(tag);
   endtask

   // scoreboard monitor: control symbols and local pulses, in cycle order
   task automatic see(int ev);
      if (exp_q.size() == 0) begin
         chk(0, "unexpected event", ev, -1);
      end else begin
         int e = exp_q.pop_front();
         string t = tag_q.pop_front();
         chk(ev == e, t, ev, e);
      end
   endtask

   always @(negedge clk) begin
      if (!rst) begin
         for (int p = 0; p < NP; p++) begin
            if (tx_valid[p] && (tx_kind[3*p +: 3] == TK_EOP_GRANT ||
                                tx_kind[3*p +: 3] == TK_ARB_RESET))
               see(p*8 + int'(tx_kind[3*p +: 3]));
         end
         if (lgrant) see(EV_LG);
         if (lreset) see(EV_LR);
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic tok(int p, logic [2:0] k, logic n, logic [PW-1:0] pr);
      rx_valid[p]      = 1'b1;
      rx_kind[3*p +: 3] = k;
      rx_nxt[p]        = n;
      rx_pri[PW*p +: PW] = pr;
   endtask

   task automatic quiet();
      rx_valid = '0; rx_kind = '0; rx_nxt = '0; rx_pri = '0;
      lreq_valid = 1'b0; lsend_done = 1'b0;
   endtask

   task automatic send1(int p, logic [2:0] k, logic n, logic [PW-1:0] pr);
      tok(p, k, n, pr);
      step();
      quiet();
   endtask

   task automatic pair(int p, logic [2:0] k);
      tok(p, k, 1'b0, '0);
      step();
      step();
      quiet();
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step();
   endtask

   // expect a request token on port 0
   task automatic req0(string tag, logic n, int pr);
      chk(tx_valid[0] && tx_kind[2:0] == TK_REQ && tx_nxt[0] == n &&
          int'(tx_pri[PW-1:0]) == pr, tag,
          int'({tx_valid[0], tx_kind[2:0], tx_nxt[0], tx_pri[PW-1:0]}),
          int'({1'b1, TK_REQ, n, PW'(pr)}));
   endtask

   initial begin
      fork
         begin
            idle(3);
            // R1 reset state
            chk(tx_valid == '0 && !lgrant && !lreset && !boss, "R1 in reset",
                int'({tx_valid, lgrant, lreset, boss}), 0);
            rst = 1'b0;
            step();
            chk(tx_valid == '0 && !lgrant && !lreset && !boss, "R1 after reset",
                int'({tx_valid, lgrant, lreset, boss}), 0);

            // R2 data repeat, port 0 becomes upstream
            send1(0, TK_DATA, 1'b0, '0);
            chk(tx_valid == 3'b110 && tx_kind[5:3] == TK_DATA && tx_kind[8:6] == TK_DATA,
                "R2 data repeat", int'({tx_valid, tx_kind}), int'({3'b110, 9'o220}));
            send1(0, TK_EOP, 1'b0, '0);
            chk(tx_valid == 3'b110 && tx_kind[5:3] == TK_EOP, "R2 eop repeat",
                int'({tx_valid, tx_kind[5:3]}), int'({3'b110, 3'd3}));

            // R3 forward, R4 class ordering
            send1(2, TK_REQ, 1'b0, 2'd1);
            req0("R3 forward cur pri1", 1'b0, 1);
            send1(1, TK_REQ, 1'b1, 2'd3);
            req0("R4 current beats next", 1'b0, 1);
            lreq_valid = 1'b1; lreq_nxt = 1'b0; lreq_pri = 2'd1;
            step(); quiet();

            // R5 single grant copy is ignored
            send1(0, TK_EOP_GRANT, 1'b0, '0);
            step();
            chk(!lgrant, "R5 single copy", int'(lgrant), 0);

            // R6 / R4 local wins tie with port 2 (index 0)
            push(EV_LG, "R4 R6 local grant");
            pair(0, TK_EOP_GRANT);
            step();
            chk(tx_valid[0] == 1'b0, "R3 silent while transmitting", int'(tx_valid[0]), 0);

            // R8 boss grants port 2 (current) over port 1 (next)
            push(2*8 + 4, "R8 grant p2 first"); push(2*8 + 4, "R8 grant p2 second");
            lsend_done = 1'b1; step(); quiet();
            chk(boss, "R8 boss after done", int'(boss), 1);
            idle(4);
            chk(!boss, "R8 boss released", int'(boss), 0);

            // R9 only next-interval request left
            for (int k = 0; k < 2; k++) begin
               push(0*8 + 5, "R9 reset p0"); push(1*8 + 5, "R9 reset p1");
               push(2*8 + 5, "R9 reset p2");
               if (k == 0) push(EV_LR, "R9 lreset");
            end
            push(1*8 + 4, "R9 grant p1 first"); push(1*8 + 4, "R9 grant p1 second");
            lsend_done = 1'b1; step(); quiet();
            idle(6);
            chk(!boss, "R9 boss released", int'(boss), 0);

            // R7 repeater arbitration reset and promotion
            send1(0, TK_DATA, 1'b0, '0);
            send1(1, TK_REQ, 1'b1, 2'd2);
            req0("R7 next before reset", 1'b1, 2);
            push(1*8 + 5, "R7 rep p1"); push(2*8 + 5, "R7 rep p2"); push(EV_LR, "R7 lreset");
            push(1*8 + 5, "R7 rep p1"); push(2*8 + 5, "R7 rep p2");
            pair(0, TK_ARB_RESET);
            req0("R7 promoted", 1'b0, 2);
            idle(2);

            // R4 higher priority, then lowest index on tie
            send1(2, TK_REQ, 1'b0, 2'd3);
            req0("R4 higher priority", 1'b0, 3);
            push(2*8 + 4, "R6 route p2"); push(2*8 + 4, "R6 route p2");
            pair(0, TK_EOP_GRANT);
            idle(2);
            req0("R6 winner cleared", 1'b0, 2);
            send1(2, TK_REQ, 1'b0, 2'd2);
            push(1*8 + 4, "R4 tie lowest port"); push(1*8 + 4, "R4 tie lowest port");
            pair(0, TK_EOP_GRANT);
            idle(2);
            push(2*8 + 4, "R6 route last"); push(2*8 + 4, "R6 route last");
            pair(0, TK_EOP_GRANT);
            idle(2);
            // R6 no request: grant dropped
            pair(0, TK_EOP_GRANT);
            idle(2);
            chk(tx_valid == '0, "R6 dropped grant", int'(tx_valid), 0);
            idle(3);
            chk(exp_q.size() == 0, "R10 all events seen", exp_q.size(), 0);
         end
         begin
            idle(20000);
            chk(0, "watchdog", 0, 1);
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule